// File: doc/BRIEF.md
# Serial NAND Power-Up Sequencer

This block runs once after each reset. It brings a serial NAND flash into a usable state over a single-lane SPI link, with no software involved. It drives the chip select itself and contains a byte shifter that works in SPI mode 0 (clock idles low, data sampled on the rising edge, most significant bit first).

The sequence has five stages:
1. It sends a device reset and polls the status register until the busy bit clears.
2. It reads the identification bytes and checks them, which fixes the device geometry.
3. It switches on the device's internal ECC.
4. It removes all block protection.
5. It ends the run.

Each configuration write is wrapped in a write-enable frame and a write-disable frame. Each configuration write is followed by a busy poll.

When the run ends, the block reports either `done` or `error`. Both are sticky until the next reset. After `done`, the block also reports whether the part is the large device and how many erase blocks it has. All devices use 2048-byte pages and 128 KiB erase blocks, so the block count is the only geometry output. The pause between status reads and the poll time-out are parameters.

Top module: `nboot_seq`

## Requirements
- R1: The first frame after reset is the single byte 0xFF. It is followed by a busy poll and then by the identification frame 0x9F 0x00 0x00 0x00.
- R2: The link uses SPI mode 0. `spi_sck` is low whenever `spi_cs_n` is high, and every frame carries exactly 8 rising clock edges per byte, most significant bit first.
- R3: Between any two frames, `spi_cs_n` stays high for at least `CS_GAP` system clocks, and for never less than one SPI clock period.
- R4: A busy poll is the frame 0x0F 0xC0 0x00. Bit 0 of the third returned byte is the busy flag, and bits 7:1 of that byte are ignored. Polling repeats until bit 0 reads 0. Between two consecutive status reads, `spi_cs_n` stays high for at least `POLL_GAP` clocks.
- R5: The third returned byte of the identification frame is the manufacturer code and the fourth is the capacity code. For manufacturer 0xC2, capacity 0x12 gives `high_cap`=0 with `blk_count`=1024, and capacity 0x22 gives `high_cap`=1 with `blk_count`=2048.
- R6: Any other manufacturer or capacity code raises `error` right after the identification frame, and no further frame is sent.
- R7: ECC is enabled by the frames 0x06, then 0x1F 0xB0 0x10, then a busy poll, then 0x04, in that order.
- R8: Unlocking follows R7: 0x06, then 0x1F 0xA0 0x00, then a busy poll, then 0x04. `done` rises only after that final frame.
- R9: If `POLL_LIMIT` status reads in a row all return busy, `error` rises and no further frame is sent. If the device reports busy `POLL_LIMIT`-1 times and then idle, the sequence goes on.
- R10: `done` and `error` are never high together, and once either is high it stays high until reset.
- R11: While reset is held, `spi_cs_n` is 1, `spi_sck` is 0, and `done`, `error`, `high_cap` and `blk_count` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; the sequence restarts when it is released |
| spi_sck | output | 1 | SPI serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select of the flash |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| done | output | 1 | Sticky: initialization finished successfully |
| error | output | 1 | Sticky: identification rejected or busy poll timed out |
| high_cap | output | 1 | Large device detected; valid with `done` |
| blk_count | output | BLK_W | Number of erase blocks; valid with `done` |

## Verification
The bench models the flash device. It varies how long each of the three busy phases lasts, and it fills bits 7:1 of the status byte with noise. A poll that looked at the whole byte would therefore never leave the loop, and a poll that ignored bit 0 would send frames while the device was still busy. The limit of the poll counter is tested from both sides: exactly `POLL_LIMIT` busy reads must fail, and one fewer must pass. An off-by-one counter would either fail a legal device or poll forever. Bad manufacturer and bad capacity codes are each tested, after which no frame may follow. The bench also measures the chip-select high time between frames, so a sequencer that joined frames or hammered the status register shows up as a short gap.

// File: rtl/nboot_pkg.sv
// Package: shared opcodes, register addresses, identification codes and
// state types for the serial NAND power-up sequencer.
// Assumes one flash device per chip select and single-lane transfers.
package nboot_pkg;

    // Command opcodes
    localparam logic [7:0] OP_RESET = 8'hFF;
    localparam logic [7:0] OP_GETF  = 8'h0F;
    localparam logic [7:0] OP_SETF  = 8'h1F;
    localparam logic [7:0] OP_RDID  = 8'h9F;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_PAD   = 8'h00;

    // Feature register addresses and the values written to them
    localparam logic [7:0] FR_STATUS = 8'hC0;
    localparam logic [7:0] FR_CONFIG = 8'hB0;
    localparam logic [7:0] FR_LOCK   = 8'hA0;
    localparam logic [7:0] CFG_ECC   = 8'h10;
    localparam logic [7:0] LOCK_NONE = 8'h00;

    // Identification codes and the matching geometry
    localparam logic [7:0] ID_MFR     = 8'hC2;
    localparam logic [7:0] ID_CAP_STD = 8'h12;
    localparam logic [7:0] ID_CAP_BIG = 8'h22;
    localparam int         BLK_STD    = 1024;
    localparam int         BLK_BIG    = 2048;

    // Main sequencer states
    typedef enum logic [2:0] {
        ST_LAUNCH,
        ST_SHIFT,
        ST_CSGAP,
        ST_PGAP,
        ST_OK,
        ST_FAIL
    } seq_state_t;

    // Steps of the fixed bring-up program, in issue order
    typedef enum logic [2:0] {
        SP_RESET,
        SP_ID,
        SP_WEN_A,
        SP_ECC,
        SP_WDI_A,
        SP_WEN_B,
        SP_UNLOCK,
        SP_WDI_B
    } step_t;

endpackage

// File: rtl/nboot_shifter.sv
// Byte shifter for SPI mode 0: the clock idles low, MOSI changes after
// the falling edge, and MISO is sampled on the rising edge, MSB first.
// Assumes start is pulsed only while no byte is in flight. Chip select
// is driven by the caller, not here.
module nboot_shifter #(
    parameter int DIV = 4            // system clocks per SPI clock half-period
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);

    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic          active;
    logic          phase;
    logic [DW-1:0] div_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;
    logic          done_q;

    // Purpose: time the half-periods, sample on rise, shift on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            phase   <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    phase   <= 1'b0;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                    tx_sh   <= tx;
                end
            end else if (div_cnt == DW'(DIV - 1)) begin
                div_cnt <= '0;
                if (!phase) begin
                    phase <= 1'b1;
                    rx_sh <= {rx_sh[6:0], miso};
                end else begin
                    phase <= 1'b0;
                    tx_sh <= {tx_sh[6:0], 1'b0};
                    if (bit_cnt == 3'd7) begin
                        active <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + DW'(1);
            end
        end
    end

    assign sclk = phase;
    assign mosi = tx_sh[7];
    assign done = done_q;
    assign rx   = rx_sh;

    // R2: a byte ends with the clock back at its idle level
    a_r2_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sclk);

    // R2: a new byte is never launched while the clock is high
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active) |=> !sclk);

endmodule

// File: rtl/nboot_frame_rom.sv
// Frame table: gives the byte to send at a given position of the current
// step (or of the busy poll), whether it is the last byte of its frame,
// and whether the step must be followed by a busy poll.
// Assumes the position index stays within the frame length.
module nboot_frame_rom
    import nboot_pkg::*;
(
    input  step_t      step,
    input  logic       in_poll,
    input  logic [1:0] idx,
    output logic [7:0] tx_byte,
    output logic       last,
    output logic       poll_after
);

    // Purpose: look up the byte, the end of frame and the poll need.
    always_comb begin
        tx_byte    = OP_PAD;
        last       = 1'b0;
        poll_after = 1'b0;
        if (in_poll) begin
            case (idx)
                2'd0:    tx_byte = OP_GETF;
                2'd1:    tx_byte = FR_STATUS;
                default: begin tx_byte = OP_PAD; last = 1'b1; end
            endcase
        end else begin
            case (step)
                SP_RESET: begin
                    tx_byte    = OP_RESET;
                    last       = 1'b1;
                    poll_after = 1'b1;
                end
                SP_ID: begin
                    tx_byte = (idx == 2'd0) ? OP_RDID : OP_PAD;
                    last    = (idx == 2'd3);
                end
                SP_WEN_A, SP_WEN_B: begin
                    tx_byte = OP_WREN;
                    last    = 1'b1;
                end
                SP_WDI_A, SP_WDI_B: begin
                    tx_byte = OP_WRDI;
                    last    = 1'b1;
                end
                SP_ECC, SP_UNLOCK: begin
                    poll_after = 1'b1;
                    case (idx)
                        2'd0:    tx_byte = OP_SETF;
                        2'd1:    tx_byte = (step == SP_ECC) ? FR_CONFIG : FR_LOCK;
                        default: begin
                            tx_byte = (step == SP_ECC) ? CFG_ECC : LOCK_NONE;
                            last    = 1'b1;
                        end
                    endcase
                end
                default: begin
                    tx_byte = OP_PAD;
                    last    = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/nboot_seq.sv
// Serial NAND power-up sequencer, top level. Runs the fixed program
// reset -> poll -> identify -> enable ECC -> poll -> unlock -> poll,
// wrapping each feature write in write-enable and write-disable frames.
// Assumes CS_GAP, POLL_GAP and POLL_LIMIT are at least 1. done/error are
// sticky until rst_n is asserted again.
module nboot_seq
    import nboot_pkg::*;
#(
    parameter int CLK_DIV    = 4,       // system clocks per SPI half-period
    parameter int CS_GAP     = 8,       // minimum chip-select high time, clocks
    parameter int POLL_GAP   = 1000,    // extra idle clocks between status reads
    parameter int POLL_LIMIT = 100000,  // busy status reads before giving up
    parameter int BLK_W      = 12       // width of the erase-block count
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             done,
    output logic             error,
    output logic             high_cap,
    output logic [BLK_W-1:0] blk_count
);

    localparam int CS_HOLD = (CS_GAP < 2 * CLK_DIV) ? 2 * CLK_DIV : CS_GAP;
    localparam int CNT_MAX = (CS_HOLD > POLL_GAP) ? CS_HOLD : POLL_GAP;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int PL_W    = $clog2(POLL_LIMIT + 1);

    seq_state_t       state;
    step_t            step;
    logic             in_poll;
    logic [1:0]       idx;
    logic [CNT_W-1:0] cnt;
    logic [PL_W-1:0]  poll_cnt;
    logic             cs_q;
    logic             start_q;
    logic             busy_bit;
    logic [7:0]       mfr_q;
    logic [7:0]       cap_q;
    logic             done_q;
    logic             err_q;
    logic             hcap_q;
    logic [BLK_W-1:0] blk_q;

    logic [7:0]       tx_byte;
    logic             last_byte;
    logic             poll_after;
    logic             sh_done;
    logic [7:0]       sh_rx;
    logic             id_ok;

    nboot_frame_rom u_rom (
        .step       (step),
        .in_poll    (in_poll),
        .idx        (idx),
        .tx_byte    (tx_byte),
        .last       (last_byte),
        .poll_after (poll_after)
    );

    nboot_shifter #(.DIV(CLK_DIV)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_q),
        .tx    (tx_byte),
        .miso  (spi_miso),
        .sclk  (spi_sck),
        .mosi  (spi_mosi),
        .done  (sh_done),
        .rx    (sh_rx)
    );

    // Purpose: accept only the known manufacturer with a known capacity.
    always_comb begin
        id_ok = (mfr_q == ID_MFR) && ((cap_q == ID_CAP_STD) || (cap_q == ID_CAP_BIG));
    end

    // Purpose: step through frames, polls, gaps and the final verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_LAUNCH;
            step     <= SP_RESET;
            in_poll  <= 1'b0;
            idx      <= '0;
            cnt      <= '0;
            poll_cnt <= '0;
            cs_q     <= 1'b1;
            start_q  <= 1'b0;
            busy_bit <= 1'b0;
            mfr_q    <= '0;
            cap_q    <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            hcap_q   <= 1'b0;
            blk_q    <= '0;
        end else begin
            start_q <= 1'b0;
            case (state)
                ST_LAUNCH: begin
                    cs_q    <= 1'b0;
                    start_q <= 1'b1;
                    state   <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (sh_done) begin
                        if (in_poll && idx == 2'd2)
                            busy_bit <= sh_rx[0];
                        if (!in_poll && step == SP_ID && idx == 2'd2)
                            mfr_q <= sh_rx;
                        if (!in_poll && step == SP_ID && idx == 2'd3)
                            cap_q <= sh_rx;
                        if (last_byte) begin
                            cs_q  <= 1'b1;
                            cnt   <= '0;
                            state <= ST_CSGAP;
                        end else begin
                            idx   <= idx + 2'd1;
                            state <= ST_LAUNCH;
                        end
                    end
                end
                ST_CSGAP: begin
                    if (cnt == CNT_W'(CS_HOLD - 1)) begin
                        cnt <= '0;
                        idx <= '0;
                        if (in_poll) begin
                            if (!busy_bit) begin
                                in_poll <= 1'b0;
                                if (step == SP_WDI_B) begin
                                    state  <= ST_OK;
                                    done_q <= 1'b1;
                                end else begin
                                    step  <= step_t'(step + 3'd1);
                                    state <= ST_LAUNCH;
                                end
                            end else if (poll_cnt == PL_W'(POLL_LIMIT - 1)) begin
                                state <= ST_FAIL;
                                err_q <= 1'b1;
                            end else begin
                                poll_cnt <= poll_cnt + PL_W'(1);
                                state    <= ST_PGAP;
                            end
                        end else if (step == SP_ID && !id_ok) begin
                            state <= ST_FAIL;
                            err_q <= 1'b1;
                        end else begin
                            if (step == SP_ID) begin
                                hcap_q <= (cap_q == ID_CAP_BIG);
                                blk_q  <= (cap_q == ID_CAP_BIG) ? BLK_W'(BLK_BIG)
                                                                : BLK_W'(BLK_STD);
                            end
                            if (poll_after) begin
                                in_poll  <= 1'b1;
                                poll_cnt <= '0;
                                state    <= ST_LAUNCH;
                            end else if (step == SP_WDI_B) begin
                                state  <= ST_OK;
                                done_q <= 1'b1;
                            end else begin
                                step  <= step_t'(step + 3'd1);
                                state <= ST_LAUNCH;
                            end
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_PGAP: begin
                    if (cnt == CNT_W'(POLL_GAP - 1)) begin
                        cnt   <= '0;
                        state <= ST_LAUNCH;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    cs_q <= 1'b1;
                end
            endcase
        end
    end

    assign spi_cs_n  = cs_q;
    assign done      = done_q;
    assign error     = err_q;
    assign high_cap  = hcap_q;
    assign blk_count = blk_q;

    // R10: the two verdicts exclude each other
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && err_q));

    // R10: a success verdict is held
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q);

    // R6: a failure verdict is held
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R6: after a verdict the bus stays quiet
    a_r6_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q || err_q) |-> (cs_q && !spi_sck));

    // R2: no clock edge while the device is deselected
    a_r2_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |-> !spi_sck);

    // R3: chip select never pulses high for a single clock
    a_r3_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_q) |=> cs_q);

    // R5: a success verdict always carries one of the two geometries
    a_r5_geometry: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ((hcap_q && blk_q == BLK_W'(BLK_BIG)) ||
                    (!hcap_q && blk_q == BLK_W'(BLK_STD))));

    // R9: the poll counter stays below its limit
    a_r9_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_poll |-> (poll_cnt < PL_W'(POLL_LIMIT)));

endmodule

// File: tb/sim_nboot_seq.sv
module sim_nboot_seq;

    localparam int DIV = 2;
    localparam int CSG = 5;
    localparam int PG  = 7;
    localparam int PL  = 5;
    localparam int BW  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spi_sck, spi_cs_n, spi_mosi;
    logic          spi_miso = 1'b0;
    logic          done, error, high_cap;
    logic [BW-1:0] blk_count;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    nboot_seq #(
        .CLK_DIV(DIV), .CS_GAP(CSG), .POLL_GAP(PG), .POLL_LIMIT(PL), .BLK_W(BW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .done(done), .error(error),
        .high_cap(high_cap), .blk_count(blk_count)
    );

    // ---------------- flash device model ----------------
    logic [7:0] mfr_v, cap_v;
    logic [6:0] stat_hi;
    int         bz [3];
    int         busy_left;
    bit         armed = 1'b0;
    int         bitn;
    logic [7:0] sh_in;
    logic [7:0] cur [4];
    logic [7:0] lf [64][4];
    int         lbits [64];
    int         gaps [64];
    int         nfr, ngap, hi_cnt;

    function automatic logic [7:0] resp_byte(input int k);
        if (k == 2 && cur[0] == 8'h0F) return {stat_hi, (busy_left > 0) ? 1'b1 : 1'b0};
        if (k == 2 && cur[0] == 8'h9F) return mfr_v;
        if (k == 3 && cur[0] == 8'h9F) return cap_v;
        return 8'h00;
    endfunction

    always @(negedge spi_cs_n) begin
        if (armed) begin
            bitn = 0;
            for (int i = 0; i < 4; i++) cur[i] = 8'h00;
            spi_miso = 1'b0;
        end
    end

    always @(posedge spi_sck) begin
        if (armed && !spi_cs_n) begin
            sh_in = {sh_in[6:0], spi_mosi};
            bitn++;
            if (bitn % 8 == 0 && bitn <= 32) cur[bitn/8 - 1] = sh_in;
        end
    end

    always @(negedge spi_sck) begin
        if (armed && !spi_cs_n) begin
            logic [7:0] rb;
            rb = resp_byte(bitn / 8);
            spi_miso = rb[7 - (bitn % 8)];
        end
    end

    always @(posedge spi_cs_n) begin
        if (armed) begin
            if (nfr < 64) begin
                for (int i = 0; i < 4; i++) lf[nfr][i] = cur[i];
                lbits[nfr] = bitn;
                nfr++;
            end
            if (cur[0] == 8'h0F && busy_left > 0) busy_left--;
            if (cur[0] == 8'hFF) busy_left = bz[0];
            if (cur[0] == 8'h1F && cur[1] == 8'hB0) busy_left = bz[1];
            if (cur[0] == 8'h1F && cur[1] == 8'hA0) busy_left = bz[2];
        end
    end

    // chip-select high time before each frame, in clocks
    always @(posedge clk) begin
        if (armed) begin
            if (spi_cs_n) hi_cnt++;
            else if (hi_cnt > 0) begin
                if (ngap < 64) gaps[ngap] = hi_cnt;
                ngap++;
                hi_cnt = 0;
            end
        end
    end

    // watchdog
    task automatic summary_and_end();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 190000)", cycles);
            summary_and_end();
        end
    end

    // ---------------- expectations ----------------
    logic [7:0] ef [64][4];
    int         elen [64];
    bit         epoll [64];
    int         nef;

    task automatic push(input logic [7:0] b0, b1, b2, b3, input int len, input bit p);
        ef[nef][0] = b0; ef[nef][1] = b1; ef[nef][2] = b2; ef[nef][3] = b3;
        elen[nef] = len; epoll[nef] = p; nef++;
    endtask

    task automatic add_polls(input int b, output bit tmo);
        int n;
        n = (b >= PL) ? PL : b + 1;
        for (int i = 0; i < n; i++) push(8'h0F, 8'hC0, 8'h00, 8'h00, 3, 1'b1);
        tmo = (b >= PL);
    endtask

    function automatic string tag_of(input logic [7:0] b0, input logic [7:0] b1);
        if (b0 == 8'hFF) return "R1";
        if (b0 == 8'h0F) return "R4";
        if (b0 == 8'h9F) return "R5";
        if (b0 == 8'h1F && b1 == 8'hA0) return "R8";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] m, input logic [7:0] c,
                       input int b0, input int b1, input int b2);
        bit exp_ok, exp_err, tmo, id_bad;
        string cnt_tag;
        mfr_v = m; cap_v = c; bz[0] = b0; bz[1] = b1; bz[2] = b2;
        busy_left = 0; stat_hi = 7'($urandom);
        armed = 1'b0; rst_n = 1'b0;
        nfr = 0; ngap = 0; hi_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check(spi_cs_n == 1'b1, "R11", "cs_n in reset", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R11", "sck in reset", spi_sck, 0);
        check({done, error, high_cap} == 3'b000, "R11", "flags in reset",
              {done, error, high_cap}, 0);
        check(blk_count == '0, "R11", "blk_count in reset", blk_count, 0);
        armed = 1'b1; rst_n = 1'b1;
        while (!(done || error)) @(negedge clk);
        repeat (300) @(negedge clk);

        // build expected frame list
        nef = 0; exp_ok = 0; exp_err = 0; id_bad = 0; tmo = 0;
        push(8'hFF, 0, 0, 0, 1, 0);
        add_polls(b0, tmo);
        if (!tmo) begin
            push(8'h9F, 0, 0, 0, 4, 0);
            id_bad = !(m == 8'hC2 && (c == 8'h12 || c == 8'h22));
            if (!id_bad) begin
                push(8'h06, 0, 0, 0, 1, 0);
                push(8'h1F, 8'hB0, 8'h10, 0, 3, 0);
                add_polls(b1, tmo);
                if (!tmo) begin
                    push(8'h04, 0, 0, 0, 1, 0);
                    push(8'h06, 0, 0, 0, 1, 0);
                    push(8'h1F, 8'hA0, 8'h00, 0, 3, 0);
                    add_polls(b2, tmo);
                    if (!tmo) begin
                        push(8'h04, 0, 0, 0, 1, 0);
                        exp_ok = 1;
                    end
                end
            end
        end
        exp_err = !exp_ok;
        cnt_tag = id_bad ? "R6" : (tmo ? "R9" : "R8");

        check(done == exp_ok, cnt_tag, "done", done, exp_ok);
        check(error == exp_err, cnt_tag, "error", error, exp_err);
        check(!(done && error), "R10", "done and error both high", {done, error}, 0);
        check(spi_sck == 1'b0 && spi_cs_n == 1'b1, "R2", "idle bus after verdict",
              {spi_cs_n, spi_sck}, 2'b10);
        if (exp_ok) begin
            check(high_cap == (c == 8'h22), "R5", "high_cap", high_cap, (c == 8'h22));
            check(blk_count == ((c == 8'h22) ? 12'd2048 : 12'd1024), "R5", "blk_count",
                  blk_count, (c == 8'h22) ? 2048 : 1024);
        end
        check(nfr == nef, cnt_tag, "frame count", nfr, nef);
        for (int i = 0; i < nef && i < nfr; i++) begin
            bit same;
            same = 1;
            for (int k = 0; k < elen[i]; k++) if (lf[i][k] != ef[i][k]) same = 0;
            check(same, tag_of(ef[i][0], ef[i][1]), $sformatf("frame %0d bytes", i),
                  {lf[i][0], lf[i][1], lf[i][2], lf[i][3]},
                  {ef[i][0], ef[i][1], ef[i][2], ef[i][3]});
            check(lbits[i] == 8 * elen[i], "R2", $sformatf("frame %0d clock edges", i),
                  lbits[i], 8 * elen[i]);
            if (i >= 1 && i < ngap) begin
                if (epoll[i] && epoll[i-1])
                    check(gaps[i] >= PG, "R4", $sformatf("gap before poll %0d", i), gaps[i], PG);
                else
                    check(gaps[i] >= CSG, "R3", $sformatf("gap before frame %0d", i), gaps[i], CSG);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed corner cases
        run(8'hC2, 8'h12, 0, 0, 0);            // R5 standard part, no busy
        run(8'hC2, 8'h22, 2, 1, 3);            // R5 large part, R4 repeated polls
        run(8'hC8, 8'h12, 1, 0, 0);            // R6 wrong manufacturer
        run(8'hC2, 8'h32, 0, 0, 0);            // R6 unknown capacity
        run(8'hC2, 8'h12, PL, 0, 0);           // R9 timeout after reset
        run(8'hC2, 8'h22, PL - 1, PL - 1, PL - 1); // R9 one read under the limit
        run(8'hC2, 8'h12, 0, PL, 0);           // R9 timeout after ECC write
        run(8'hC2, 8'h22, 0, 0, PL);           // R9 timeout after unlock
        // random scenarios
        for (int n = 0; n < 6; n++) begin
            logic [7:0] m, c;
            int sel;
            sel = $urandom % 8;
            m = 8'hC2;
            c = ($urandom % 2) ? 8'h22 : 8'h12;
            if (sel == 0) m = 8'hC2 ^ (8'($urandom % 255) + 8'd1);
            if (sel == 1) c = 8'h12 ^ 8'h40;
            run(m, c, $urandom % (PL + 1), $urandom % (PL + 1), $urandom % (PL + 1));
        end
        summary_and_end();
    end

endmodule